// File: doc/BRIEF.md
# Link-Layer Frame Receiver with Additive Checksum

This block sits behind a two-wire bus slave byte engine. The engine has already matched the slave address. It hands over each received byte as a one-cycle strobe, and it also gives one-cycle strobes for START (or repeated START) and for STOP. The block turns that stream into link-layer frames.

Each frame has three parts, in this order:
- a header byte that gives the data count and a 5-bit module identifier;
- a checksum byte;
- the data bytes, from one to eight of them.

Once the last announced data byte arrives, the block adds up the data bytes modulo 256. It subtracts that sum from the received checksum. It then raises exactly one of two pulses: frame accepted, or retransmission requested. The block also reports three kinds of badly formed traffic: void messages, truncated frames and surplus bytes.

All outputs are registered. An event accepted at a clock edge shows its effect during the following cycle. The frame outputs (module, count, data) keep their values until the next frame completes. Whoever collects housekeeping or commands reads these outputs on either verdict pulse.

Top module: `pkt_frame_rx`

## Requirements
- R1: A header byte h gives a data count of h[7:5] + 1 (range 1 to 8) and a module identifier of h[4:0]. When the frame completes, these appear on `frm_count` and `frm_module`.
- R2: The byte after the header is the checksum. The bytes after that are data, stored in arrival order: data byte i appears on `frm_data[8*i+7:8*i]`. Lanes at or above the count read as zero. The frame completes in the cycle that follows the acceptance of the last announced data byte.
- R3: If (checksum − data sum) mod 256 equals 0, `frm_ok` pulses for exactly one cycle.
- R4: If that difference is not zero, `retx_req` pulses for exactly one cycle.
- R5: In any one cycle, at most one of `frm_ok`, `retx_req`, `void_err`, `trunc_err` and `ovr_err` is high. Each completed frame raises exactly one verdict.
- R6: A START strobe returns the parser to waiting for a header, whatever state it is in. Any partial frame is dropped and raises no pulse. A byte strobe in the same cycle as START is ignored.
- R7: A STOP that follows START with no byte in between pulses `void_err`. No frame is produced.
- R8: A STOP that comes after at least one byte of a frame, but before its last announced data byte, pulses `trunc_err`. The frame outputs keep their previous values.
- R9: Each byte that arrives after a frame has completed, and before the next STOP or START, pulses `ovr_err`. It leaves the frame outputs unchanged.
- R10: `frm_module`, `frm_count` and `frm_data` change only in a cycle where `frm_ok` or `retx_req` is high.
- R11: Byte strobes are ignored while no START has been seen since reset or since the last STOP.
- R12: When a byte strobe and a STOP come in the same cycle, the byte is processed first. The STOP is then judged against the updated state, so a final data byte together with STOP completes the frame without `trunc_err`.
- R13: After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_evt | input | 1 | START or repeated START seen (one-cycle strobe) |
| stop_evt | input | 1 | STOP seen (one-cycle strobe) |
| byte_vld | input | 1 | A received byte is present on `byte_data` |
| byte_data | input | 8 | Received byte |
| frm_ok | output | 1 | Frame complete, checksum matched |
| retx_req | output | 1 | Frame complete, checksum mismatch; request resend |
| void_err | output | 1 | START immediately followed by STOP |
| trunc_err | output | 1 | STOP arrived before all announced data |
| ovr_err | output | 1 | Byte beyond the announced count |
| frm_module | output | 5 | Module identifier of the last completed frame |
| frm_count | output | 4 | Data byte count of the last completed frame |
| frm_data | output | 64 | Data bytes of the last completed frame, lane 0 in the low byte |

## Verification
Two functions can fall in the same cycle. One is the completion of a frame by its final data byte. The other is the STOP handling that would otherwise call the frame truncated.

The bench raises the byte strobe and the STOP strobe together on the last data byte. It expects one `frm_ok`, no `trunc_err`, and the new data on the outputs.

A second collision also gets its own case: START arriving together with a byte. The byte has to vanish. The bench shows this by following the pair with a one-byte frame, which must be reported with a count of one.

// File: rtl/pkt_rx_pkg.sv
package pkt_rx_pkg;

    localparam int BYTE_W   = 8;
    localparam int CNT_W    = 3;
    localparam int MOD_W    = BYTE_W - CNT_W;
    localparam int MAX_DATA = 1 << CNT_W;
    localparam int IDX_W    = CNT_W + 1;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_SUM,
        ST_DATA,
        ST_DONE
    } rx_state_e;

    typedef struct packed {
        logic [MOD_W-1:0] module_id;
        logic [IDX_W-1:0] count;
    } hdr_info_t;

    typedef struct packed {
        logic ok;
        logic bad;
        logic void_msg;
        logic trunc;
        logic ovr;
    } rx_evt_t;

    function automatic hdr_info_t decode_hdr(input byte_t h);
        hdr_info_t r;
        r.module_id = h[MOD_W-1:0];
        r.count     = {1'b0, h[BYTE_W-1:MOD_W]} + IDX_W'(1);
        return r;
    endfunction

    function automatic logic sum_matches(input byte_t csum, input byte_t sum);
        byte_t diff;
        diff = csum - sum;
        return (diff == '0);
    endfunction

endpackage

// File: rtl/pkt_rx_sum.sv
module pkt_rx_sum
    import pkt_rx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  logic  add_en,
    input  byte_t byte_in,
    output byte_t sum_next
);

    byte_t sum_q;

    assign sum_next = sum_q + byte_in;

    always_ff @(posedge clk) begin
        if (rst || clr)
            sum_q <= '0;
        else if (add_en)
            sum_q <= sum_next;
    end

endmodule

// File: rtl/pkt_rx_store.sv
module pkt_rx_store
    import pkt_rx_pkg::*;
#(
    parameter int NLANE = MAX_DATA
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        clr,
    input  logic                        we,
    input  logic [IDX_W-1:0]            idx,
    input  byte_t                       byte_in,
    input  logic                        commit,
    input  hdr_info_t                   hdr_in,
    output logic [NLANE-1:0][BYTE_W-1:0] data_out,
    output hdr_info_t                   hdr_out
);

    logic [NLANE-1:0][BYTE_W-1:0] stage_q;
    logic [NLANE-1:0][BYTE_W-1:0] stage_n;

    for (genvar i = 0; i < NLANE; i++) begin : g_lane
        always_comb begin
            stage_n[i] = (we && idx == IDX_W'(i)) ? byte_in : stage_q[i];
        end

        always_ff @(posedge clk) begin
            if (rst || clr)
                stage_q[i] <= '0;
            else
                stage_q[i] <= stage_n[i];
        end

        always_ff @(posedge clk) begin
            if (rst)
                data_out[i] <= '0;
            else if (commit)
                data_out[i] <= stage_n[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            hdr_out <= '0;
        else if (commit)
            hdr_out <= hdr_in;
    end

endmodule

// File: rtl/pkt_rx_parser.sv
module pkt_rx_parser
    import pkt_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start_evt,
    input  logic             stop_evt,
    input  logic             byte_vld,
    input  byte_t            byte_in,
    input  byte_t            sum_next,
    output logic             seq_clr,
    output logic             data_we,
    output logic [IDX_W-1:0] data_idx,
    output logic             commit,
    output hdr_info_t        hdr_q,
    output rx_evt_t          evt_q
);

    rx_state_e        state_q, state_n, state_b;
    logic [IDX_W-1:0] got_q, got_n;
    byte_t            csum_q, csum_n;
    hdr_info_t        hdr_n;
    rx_evt_t          evt_n;

    always_comb begin
        state_b  = state_q;
        state_n  = state_q;
        hdr_n    = hdr_q;
        csum_n   = csum_q;
        got_n    = got_q;
        evt_n    = '0;
        seq_clr  = 1'b0;
        data_we  = 1'b0;
        commit   = 1'b0;
        data_idx = got_q;

        if (start_evt) begin
            seq_clr = 1'b1;
            got_n   = '0;
            state_n = ST_HDR;
        end else begin
            if (byte_vld) begin
                unique case (state_q)
                    ST_HDR: begin
                        hdr_n   = decode_hdr(byte_in);
                        state_b = ST_SUM;
                    end
                    ST_SUM: begin
                        csum_n  = byte_in;
                        got_n   = '0;
                        state_b = ST_DATA;
                    end
                    ST_DATA: begin
                        data_we = 1'b1;
                        got_n   = got_q + IDX_W'(1);
                        if (got_n == hdr_q.count) begin
                            commit  = 1'b1;
                            state_b = ST_DONE;
                            if (sum_matches(csum_q, sum_next))
                                evt_n.ok = 1'b1;
                            else
                                evt_n.bad = 1'b1;
                        end
                    end
                    ST_DONE: evt_n.ovr = 1'b1;
                    default: ;
                endcase
            end
            state_n = state_b;
            if (stop_evt) begin
                unique case (state_b)
                    ST_HDR:          evt_n.void_msg = 1'b1;
                    ST_SUM, ST_DATA: evt_n.trunc    = 1'b1;
                    default: ;
                endcase
                state_n = ST_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            got_q   <= '0;
            csum_q  <= '0;
            hdr_q   <= '0;
            evt_q   <= '0;
        end else begin
            state_q <= state_n;
            got_q   <= got_n;
            csum_q  <= csum_n;
            hdr_q   <= hdr_n;
            evt_q   <= evt_n;
        end
    end

endmodule

// File: rtl/pkt_frame_rx.sv
module pkt_frame_rx
    import pkt_rx_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         start_evt,
    input  logic                         stop_evt,
    input  logic                         byte_vld,
    input  logic [BYTE_W-1:0]            byte_data,
    output logic                         frm_ok,
    output logic                         retx_req,
    output logic                         void_err,
    output logic                         trunc_err,
    output logic                         ovr_err,
    output logic [MOD_W-1:0]             frm_module,
    output logic [IDX_W-1:0]             frm_count,
    output logic [MAX_DATA*BYTE_W-1:0]   frm_data
);

    logic             seq_clr, data_we, commit;
    logic [IDX_W-1:0] data_idx;
    byte_t            sum_next;
    hdr_info_t        hdr_cur, hdr_done;
    rx_evt_t          evt;
    logic [MAX_DATA-1:0][BYTE_W-1:0] lanes;

    pkt_rx_parser u_parser (
        .clk       (clk),
        .rst       (rst),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .byte_vld  (byte_vld),
        .byte_in   (byte_data),
        .sum_next  (sum_next),
        .seq_clr   (seq_clr),
        .data_we   (data_we),
        .data_idx  (data_idx),
        .commit    (commit),
        .hdr_q     (hdr_cur),
        .evt_q     (evt)
    );

    pkt_rx_sum u_sum (
        .clk      (clk),
        .rst      (rst),
        .clr      (seq_clr),
        .add_en   (data_we),
        .byte_in  (byte_data),
        .sum_next (sum_next)
    );

    pkt_rx_store #(.NLANE(MAX_DATA)) u_store (
        .clk      (clk),
        .rst      (rst),
        .clr      (seq_clr),
        .we       (data_we),
        .idx      (data_idx),
        .byte_in  (byte_data),
        .commit   (commit),
        .hdr_in   (hdr_cur),
        .data_out (lanes),
        .hdr_out  (hdr_done)
    );

    assign frm_ok     = evt.ok;
    assign retx_req   = evt.bad;
    assign void_err   = evt.void_msg;
    assign trunc_err  = evt.trunc;
    assign ovr_err    = evt.ovr;
    assign frm_module = hdr_done.module_id;
    assign frm_count  = hdr_done.count;
    assign frm_data   = lanes;

endmodule

// File: rtl/pkt_rx_chk.sv
module pkt_rx_chk
    import pkt_rx_pkg::*;
(
    input logic                       clk,
    input logic                       rst,
    input logic                       start_evt,
    input logic                       stop_evt,
    input logic                       byte_vld,
    input logic                       frm_ok,
    input logic                       retx_req,
    input logic                       void_err,
    input logic                       trunc_err,
    input logic                       ovr_err,
    input logic [MOD_W-1:0]           frm_module,
    input logic [IDX_W-1:0]           frm_count,
    input logic [MAX_DATA*BYTE_W-1:0] frm_data
);

    a_r5_one_event: assert property (@(posedge clk) disable iff (rst)
        $onehot0({frm_ok, retx_req, void_err, trunc_err, ovr_err}));

    a_r10_outputs_held: assert property (@(posedge clk) disable iff (rst)
        !(frm_ok || retx_req) |-> ($stable(frm_data) && $stable(frm_count) && $stable(frm_module)));

    a_r6_start_silences: assert property (@(posedge clk) disable iff (rst)
        start_evt |=> !(frm_ok || retx_req || void_err || trunc_err || ovr_err));

    a_r7_void_after_stop: assert property (@(posedge clk) disable iff (rst)
        void_err |-> $past(stop_evt));

    a_r8_trunc_after_stop: assert property (@(posedge clk) disable iff (rst)
        trunc_err |-> $past(stop_evt));

    a_r3_verdict_after_byte: assert property (@(posedge clk) disable iff (rst)
        (frm_ok || retx_req) |-> $past(byte_vld));

    a_r9_overrun_after_byte: assert property (@(posedge clk) disable iff (rst)
        ovr_err |-> $past(byte_vld));

    a_r1_count_range: assert property (@(posedge clk) disable iff (rst)
        (frm_ok || retx_req) |-> (frm_count >= IDX_W'(1) && frm_count <= IDX_W'(MAX_DATA)));

endmodule

bind pkt_frame_rx pkt_rx_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .start_evt  (start_evt),
    .stop_evt   (stop_evt),
    .byte_vld   (byte_vld),
    .frm_ok     (frm_ok),
    .retx_req   (retx_req),
    .void_err   (void_err),
    .trunc_err  (trunc_err),
    .ovr_err    (ovr_err),
    .frm_module (frm_module),
    .frm_count  (frm_count),
    .frm_data   (frm_data)
);

// File: tb/tb_pkt_frame_rx.sv
`timescale 1ns/1ps
module tb_pkt_frame_rx;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_evt = 1'b0, stop_evt = 1'b0, byte_vld = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        frm_ok, retx_req, void_err, trunc_err, ovr_err;
    logic [4:0]  frm_module;
    logic [3:0]  frm_count;
    logic [63:0] frm_data;

    int n_chk = 0, n_fail = 0;
    int c_ok = 0, c_bad = 0, c_void = 0, c_trunc = 0, c_ovr = 0;

    always #2.5 clk = ~clk;

    pkt_frame_rx dut (
        .clk(clk), .rst(rst), .start_evt(start_evt), .stop_evt(stop_evt),
        .byte_vld(byte_vld), .byte_data(byte_data),
        .frm_ok(frm_ok), .retx_req(retx_req), .void_err(void_err),
        .trunc_err(trunc_err), .ovr_err(ovr_err),
        .frm_module(frm_module), .frm_count(frm_count), .frm_data(frm_data)
    );

    always @(negedge clk) begin
        if (!rst) begin
            c_ok    += int'(frm_ok);
            c_bad   += int'(retx_req);
            c_void  += int'(void_err);
            c_trunc += int'(trunc_err);
            c_ovr   += int'(ovr_err);
        end
    end

    task automatic chk(input bit cond, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic put_byte(input logic [7:0] b, input bit with_stop);
        @(negedge clk);
        byte_data = b; byte_vld = 1'b1; stop_evt = with_stop;
        @(negedge clk);
        byte_vld = 1'b0; stop_evt = 1'b0;
    endtask

    task automatic put_start();
        @(negedge clk); start_evt = 1'b1;
        @(negedge clk); start_evt = 1'b0;
    endtask

    task automatic put_stop();
        @(negedge clk); stop_evt = 1'b1;
        @(negedge clk); stop_evt = 1'b0;
    endtask

    task automatic settle();
        @(negedge clk); #1;
    endtask

    function automatic logic [7:0] dbyte(input int base, input int i);
        return 8'((base + i * 37 + i * i) & 255);
    endfunction

    function automatic logic [63:0] exp_lanes(input int n, input int base);
        logic [63:0] v = '0;
        for (int i = 0; i < n; i++) v[8*i +: 8] = dbyte(base, i);
        return v;
    endfunction

    // sends header, checksum and n data bytes; last byte optionally with STOP
    task automatic send_frame(input int n, input int md, input int base, input bit corrupt, input bit stop_with_last);
        logic [7:0] sum = '0;
        for (int i = 0; i < n; i++) sum += dbyte(base, i);
        put_byte({3'(n - 1), 5'(md)}, 1'b0);
        put_byte(sum + 8'(corrupt ? 1 : 0), 1'b0);
        for (int i = 0; i < n; i++) put_byte(dbyte(base, i), stop_with_last && (i == n - 1));
    endtask

    initial begin
        int ok0, bad0, vd0, tr0, ov0;
        logic [63:0] held;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #1;
        // R13 reset state
        chk({frm_ok, retx_req, void_err, trunc_err, ovr_err} == 5'b0, "R13 pulses", '0, '0);
        chk(frm_data == '0 && frm_count == '0 && frm_module == '0, "R13 frame outputs", frm_data, '0);

        // R11 bytes outside a frame ignored
        put_byte(8'h20, 1'b0); put_byte(8'h11, 1'b0); put_byte(8'h11, 1'b0);
        settle();
        chk(c_ok + c_bad + c_ovr == 0, "R11 no pulse outside frame", 64'(c_ok + c_bad + c_ovr), 0);
        chk(frm_data == '0, "R11 data untouched", frm_data, '0);

        // R1 R2 R3 R4 R5 sweep over all counts, patterns, good and corrupt sums
        for (int n = 1; n <= 8; n++) begin
            for (int p = 0; p < 3; p++) begin
                for (int c = 0; c < 2; c++) begin
                    int md = (n * 7 + p * 11 + c) % 32;
                    int base = p * 91 + n * 13 + 200 * p;
                    ok0 = c_ok; bad0 = c_bad;
                    put_start();
                    send_frame(n, md, base, c != 0, 1'b0);
                    settle();
                    chk(c_ok - ok0 == (c == 0 ? 1 : 0), "R3 ok pulse", 64'(c_ok - ok0), 64'(c == 0));
                    chk(c_bad - bad0 == (c == 1 ? 1 : 0), "R4 retx pulse", 64'(c_bad - bad0), 64'(c == 1));
                    chk((c_ok - ok0) + (c_bad - bad0) == 1, "R5 one verdict", 64'((c_ok - ok0) + (c_bad - bad0)), 1);
                    chk(frm_count == 4'(n), "R1 count", 64'(frm_count), 64'(n));
                    chk(frm_module == 5'(md), "R1 module", 64'(frm_module), 64'(md));
                    chk(frm_data == exp_lanes(n, base), "R2 data lanes", frm_data, exp_lanes(n, base));
                    put_stop();
                end
            end
        end

        // R7 void message
        held = frm_data; vd0 = c_void; ok0 = c_ok;
        put_start(); put_stop(); settle();
        chk(c_void - vd0 == 1, "R7 void pulse", 64'(c_void - vd0), 1);
        chk(c_ok == ok0 && frm_data == held, "R7 no frame", frm_data, held);

        // R8 truncated after some data, and after header only
        tr0 = c_trunc;
        put_start();
        put_byte({3'd3, 5'd9}, 1'b0); put_byte(8'h55, 1'b0); put_byte(8'h01, 1'b0); put_byte(8'h02, 1'b0);
        put_stop(); settle();
        chk(c_trunc - tr0 == 1, "R8 trunc pulse mid-data", 64'(c_trunc - tr0), 1);
        chk(frm_data == held, "R8 outputs held", frm_data, held);
        put_start(); put_byte(8'h00, 1'b0); put_stop(); settle();
        chk(c_trunc - tr0 == 2, "R8 trunc after header", 64'(c_trunc - tr0), 2);

        // R6 restart mid-frame
        ok0 = c_ok; bad0 = c_bad;
        put_start();
        put_byte({3'd2, 5'd4}, 1'b0); put_byte(8'h77, 1'b0); put_byte(8'h10, 1'b0);
        put_start();
        send_frame(2, 17, 5, 1'b0, 1'b0);
        settle();
        chk(c_ok - ok0 == 1 && c_bad == bad0, "R6 restart one ok", 64'(c_ok - ok0), 1);
        chk(frm_data == exp_lanes(2, 5) && frm_module == 5'd17, "R6 new frame data", frm_data, exp_lanes(2, 5));

        // R9 overrun bytes after completion
        ov0 = c_ovr; held = frm_data; tr0 = c_trunc;
        put_byte(8'hAA, 1'b0); put_byte(8'hBB, 1'b0);
        put_stop(); settle();
        chk(c_ovr - ov0 == 2, "R9 overrun count", 64'(c_ovr - ov0), 2);
        chk(frm_data == held && c_trunc == tr0, "R9 outputs unchanged", frm_data, held);

        // R12 last byte together with STOP
        ok0 = c_ok; tr0 = c_trunc;
        put_start();
        send_frame(3, 30, 77, 1'b0, 1'b1);
        settle();
        chk(c_ok - ok0 == 1, "R12 ok with stop", 64'(c_ok - ok0), 1);
        chk(c_trunc == tr0, "R12 no trunc", 64'(c_trunc - tr0), 0);
        chk(frm_data == exp_lanes(3, 77), "R12 data", frm_data, exp_lanes(3, 77));

        // R6 byte with START ignored
        ok0 = c_ok;
        @(negedge clk); start_evt = 1'b1; byte_vld = 1'b1; byte_data = 8'hFF;
        @(negedge clk); start_evt = 1'b0; byte_vld = 1'b0;
        send_frame(1, 3, 40, 1'b0, 1'b0);
        settle();
        chk(c_ok - ok0 == 1 && frm_count == 4'd1, "R6 start-byte ignored", 64'(frm_count), 1);
        put_stop();

        // R10 held across idle cycles
        held = frm_data;
        repeat (5) @(negedge clk);
        #1;
        chk(frm_data == held, "R10 hold", frm_data, held);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule